// File: doc/BRIEF.md
# Floppy Disk Controller Host Phase Sequencer

This block is the processor-facing half of a floppy disk controller that works by polling only. The host sees two registers. One is a read-only status word that tells it when a byte may move and in which direction. The other is a data register that it writes or reads one byte at a time. Every operation goes through three phases in a fixed order. In the command phase the host writes all the bytes of a command. In the execution phase sector bytes come from a drive-side byte stream and the host reads them out. In the result phase the controller presents status bytes, and the host must read all of them before the controller will take a new command.

The drive side is a simple request/acknowledge stub. The controller raises a request when it wants the next sector byte. The stub answers with an acknowledge carrying a byte, or with an end-of-data pulse that cuts the transfer short. Encoding, seeking and CRC checking are outside the block.

Top module: `fdc_host_seq`

## Requirements
- R1: After reset the status word reads 0x80 (ready, host-to-controller, idle) and the data output reads 0x00.
- R2: The low 5 bits of the first command byte select the command length: code 0x06 (read sectors) needs 9 bytes and code 0x03 (set timing) needs 3 bytes. Until the last byte arrives the block stays in the command phase, with status bit 6 = 0 and bit 5 = 0. From the first accepted byte onward, bit 4 (busy) reads 1.
- R3: The 3-byte set-timing command has no execution phase and no result phase. After its last byte busy clears, and the status word returns to 0x80.
- R4: Any other code in the low 5 bits of the first byte goes straight to a result phase that holds one byte, 0x80. During that phase the status word reads 0xD0.
- R5: For a read-sectors command the execution phase moves SECTOR_BYTES bytes from the drive stream to the host, in arrival order. While a byte is offered, the status word reads 0xF0 with the selected drive's busy bit set, and that bit is bit (byte1[1:0]).
- R6: A completed read returns seven result bytes in order: ST0 = {2'b00, 3'b000, byte1[2:0]}, ST1 = 0x00, ST2 = 0x00, then command bytes 2, 3, 4 and 5 (track, head, sector, size code).
- R7: If the drive stream signals end-of-data before all sector bytes have moved, the execution phase stops at once. The seven-byte result then has ST0 bits 7:6 = 01 and ST1 = 0x04.
- R8: A host write while status bit 6 is 1, a host read while bit 6 is 0, and either strobe while bit 7 is 0 are all ignored. The status word and the phase position are left unchanged.
- R9: Busy stays set through the whole result phase, and no command byte is accepted until the last result byte is read. After that read the status word returns to 0x80.
- R10: After each accepted byte, status bit 7 reads 0 on the next clock. It rises again only when the next byte can be taken or supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_stb | input | 1 | Host write strobe for the data register |
| host_rd_stb | input | 1 | Host read strobe for the data register |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte offered to the host |
| msr | output | 8 | Status word: 7 ready, 6 direction, 5 execution, 4 busy, 3:0 drive busy |
| drv_req | output | 1 | Request for the next sector byte |
| drv_ack | input | 1 | Drive stub supplies a byte on drv_data |
| drv_eod | input | 1 | Drive stub ends the data early |
| drv_data | input | 8 | Sector byte from the drive stub |

## Verification
Some rules are checked on every cycle by assertions. The ready flag drops after each accepted byte. Busy covers both the output direction and the execution flag. A pending drive request is never overlapped by an offered byte. The command and result positions hold still unless a valid strobe arrives. Other behaviour only the bench scenarios can show: the command lengths, the byte contents and order of the result record for each drive and head, the abnormal code for an early end at every byte position, and the single invalid-command byte for every unknown opcode.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int CMD_MAX   = 9;
  localparam int CNT_W     = $clog2(CMD_MAX + 1);
  localparam int DRIVES    = 4;
  localparam int DSEL_W    = $clog2(DRIVES);
  localparam int RES_LEN   = 7;
  localparam int RIDX_W    = $clog2(RES_LEN + 1);

  localparam logic [4:0] CODE_READ = 5'h06;
  localparam logic [4:0] CODE_TIME = 5'h03;
  localparam int LEN_READ  = 9;
  localparam int LEN_TIME  = 3;

  localparam logic [7:0] ST0_INVALID = 8'h80;
  localparam logic [1:0] ST0_ABNORMAL = 2'b01;
  localparam logic [7:0] ST1_NO_DATA = 8'h04;

  typedef enum logic [1:0] {PH_CMD, PH_EXEC, PH_RES} phase_t;
endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_pkg::*;
(
  input  logic [4:0]       code,
  output logic [CNT_W-1:0] cmd_len,
  output logic             known,
  output logic             has_exec
);
  always_comb begin
    cmd_len  = CNT_W'(1);
    known    = 1'b0;
    has_exec = 1'b0;
    case (code)
      CODE_READ: begin
        cmd_len  = CNT_W'(LEN_READ);
        known    = 1'b1;
        has_exec = 1'b1;
      end
      CODE_TIME: begin
        cmd_len  = CNT_W'(LEN_TIME);
        known    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fdc_result_rec.sv
module fdc_result_rec
  import fdc_pkg::*;
(
  input  logic [RIDX_W-1:0] idx,
  input  logic              invalid,
  input  logic              abnormal,
  input  logic [DSEL_W:0]   unit_head,
  input  logic [3:0][7:0]   chrn,
  output logic [7:0]        res_byte
);
  logic [7:0] st0;

  always_comb begin
    st0 = {abnormal ? ST0_ABNORMAL : 2'b00, {(6-DSEL_W-1){1'b0}}, unit_head};
    if (invalid) st0 = ST0_INVALID;
  end

  always_comb begin
    case (idx)
      RIDX_W'(0): res_byte = st0;
      RIDX_W'(1): res_byte = abnormal ? ST1_NO_DATA : 8'h00;
      RIDX_W'(2): res_byte = 8'h00;
      RIDX_W'(3): res_byte = chrn[0];
      RIDX_W'(4): res_byte = chrn[1];
      RIDX_W'(5): res_byte = chrn[2];
      RIDX_W'(6): res_byte = chrn[3];
      default:    res_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
  import fdc_pkg::*;
#(
  parameter int SECTOR_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr_stb,
  input  logic       host_rd_stb,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] msr,
  output logic       drv_req,
  input  logic       drv_ack,
  input  logic       drv_eod,
  input  logic [7:0] drv_data
);
  localparam int XW = $clog2(SECTOR_BYTES + 1);

  phase_t             phase_q;
  logic               rqm_q, busy_q, req_q, exec_q, inval_q, abn_q;
  logic [CNT_W-1:0]   cnt_q, len_q;
  logic [XW-1:0]      xfer_q;
  logic [RIDX_W-1:0]  ridx_q, rlen_q;
  logic [DSEL_W:0]    sel_q;
  logic [3:0][7:0]    chrn_q;
  logic [7:0]         rdata_q;

  logic [CNT_W-1:0]   dec_len;
  logic               dec_known, dec_exec;
  logic [7:0]         res_byte;
  logic               wr_acc, rd_acc, dio, exm;
  logic [DRIVES-1:0]  drv_busy;

  fdc_cmd_decode u_decode (
    .code     (host_wdata[4:0]),
    .cmd_len  (dec_len),
    .known    (dec_known),
    .has_exec (dec_exec)
  );

  fdc_result_rec u_result (
    .idx       (ridx_q),
    .invalid   (inval_q),
    .abnormal  (abn_q),
    .unit_head (sel_q),
    .chrn      (chrn_q),
    .res_byte  (res_byte)
  );

  assign dio    = (phase_q != PH_CMD);
  assign exm    = (phase_q == PH_EXEC);
  assign wr_acc = host_wr_stb && rqm_q && !dio;
  assign rd_acc = host_rd_stb && rqm_q && dio;

  for (genvar g = 0; g < DRIVES; g++) begin : g_drv
    assign drv_busy[g] = exm && (sel_q[DSEL_W-1:0] == DSEL_W'(g));
  end

  assign msr        = {rqm_q, dio, exm, busy_q, drv_busy};
  assign host_rdata = rdata_q;
  assign drv_req    = req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CMD;
      rqm_q   <= 1'b1;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      exec_q  <= 1'b0;
      inval_q <= 1'b0;
      abn_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      xfer_q  <= '0;
      ridx_q  <= '0;
      rlen_q  <= '0;
      sel_q   <= '0;
      chrn_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (phase_q)
        PH_CMD: begin
          if (wr_acc) begin
            rqm_q  <= 1'b0;
            busy_q <= 1'b1;
            if (cnt_q == '0) begin
              if (!dec_known) begin
                phase_q <= PH_RES;
                inval_q <= 1'b1;
                abn_q   <= 1'b0;
                ridx_q  <= '0;
                rlen_q  <= RIDX_W'(1);
              end else begin
                len_q  <= dec_len;
                exec_q <= dec_exec;
                cnt_q  <= CNT_W'(1);
              end
            end else begin
              if (cnt_q == CNT_W'(1)) sel_q <= host_wdata[DSEL_W:0];
              if (cnt_q >= CNT_W'(2) && cnt_q <= CNT_W'(5))
                chrn_q[2'(cnt_q - CNT_W'(2))] <= host_wdata;
              if (cnt_q + CNT_W'(1) == len_q) begin
                cnt_q <= '0;
                if (exec_q) begin
                  phase_q <= PH_EXEC;
                  req_q   <= 1'b1;
                  xfer_q  <= '0;
                  inval_q <= 1'b0;
                  abn_q   <= 1'b0;
                end else begin
                  busy_q <= 1'b0;
                end
              end else begin
                cnt_q <= cnt_q + CNT_W'(1);
              end
            end
          end else begin
            rqm_q <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (req_q && drv_ack) begin
            rdata_q <= drv_data;
            rqm_q   <= 1'b1;
            req_q   <= 1'b0;
          end else if (req_q && drv_eod) begin
            req_q   <= 1'b0;
            abn_q   <= 1'b1;
            phase_q <= PH_RES;
            ridx_q  <= '0;
            rlen_q  <= RIDX_W'(RES_LEN);
            rqm_q   <= 1'b0;
          end else if (rd_acc) begin
            rqm_q <= 1'b0;
            if (xfer_q == XW'(SECTOR_BYTES - 1)) begin
              phase_q <= PH_RES;
              ridx_q  <= '0;
              rlen_q  <= RIDX_W'(RES_LEN);
            end else begin
              xfer_q <= xfer_q + XW'(1);
              req_q  <= 1'b1;
            end
          end
        end
        PH_RES: begin
          rdata_q <= res_byte;
          if (rd_acc) begin
            rqm_q <= 1'b0;
            if (ridx_q + RIDX_W'(1) == rlen_q) begin
              phase_q <= PH_CMD;
              busy_q  <= 1'b0;
              ridx_q  <= '0;
            end else begin
              ridx_q <= ridx_q + RIDX_W'(1);
            end
          end else begin
            rqm_q <= 1'b1;
          end
        end
        default: phase_q <= PH_CMD;
      endcase
    end
  end

  // R10
  wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> !rqm_q);

  // R10
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> !rqm_q);

  // R5
  exm_busy_chk: assert property (@(posedge clk) disable iff (rst)
    msr[5] |-> msr[4]);

  // R5
  req_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (exm && req_q) |-> !rqm_q);

  // R9
  dio_busy_chk: assert property (@(posedge clk) disable iff (rst)
    msr[6] |-> msr[4]);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RES && !host_rd_stb) |=> (phase_q == PH_RES) && $stable(ridx_q));

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CMD && cnt_q != '0 && !host_wr_stb) |=> (phase_q == PH_CMD) && $stable(cnt_q));
endmodule

// File: tb/test_fdc_host_seq.sv
module test_fdc_host_seq;
  localparam int SEC = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr_stb = 1'b0, host_rd_stb = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata, msr;
  logic       drv_req;
  logic       drv_ack = 1'b0, drv_eod = 1'b0;
  logic [7:0] drv_data = '0;

  int checks = 0, fails = 0, cyc = 0;
  int eod_at = 99, dcount = 0;
  logic [7:0] seed = '0;

  fdc_host_seq #(.SECTOR_BYTES(SEC)) i_fdc_host_seq (
    .clk(clk), .rst(rst),
    .host_wr_stb(host_wr_stb), .host_rd_stb(host_rd_stb),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .msr(msr),
    .drv_req(drv_req), .drv_ack(drv_ack), .drv_eod(drv_eod), .drv_data(drv_data)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    drv_ack = 1'b0;
    drv_eod = 1'b0;
    if (drv_req) begin
      if (dcount == eod_at) drv_eod = 1'b1;
      else begin
        drv_ack  = 1'b1;
        drv_data = seed + 8'(dcount * 7);
        dcount++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_rqm(input logic dir, input string req);
    int n = 0;
    while (!(msr[7] && msr[6] == dir) && n < 2000) begin
      @(negedge clk); n++;
    end
    if (n >= 2000) chk(1'b0, req, msr, {1'b1, dir, 6'b0});
  endtask

  task automatic host_write(input logic [7:0] b, input string req);
    wait_rqm(1'b0, req);
    host_wdata = b; host_wr_stb = 1'b1;
    @(negedge clk);
    host_wr_stb = 1'b0;
    chk(msr[7] == 1'b0, "R10", msr[7], 0);
  endtask

  task automatic host_read(output logic [7:0] b, input string req);
    wait_rqm(1'b1, req);
    b = host_rdata; host_rd_stb = 1'b1;
    @(negedge clk);
    host_rd_stb = 1'b0;
    chk(msr[7] == 1'b0, "R10", msr[7], 0);
  endtask

  task automatic do_read(input int d, input int h, input logic [7:0] c, input logic [7:0] hh,
                         input logic [7:0] r, input logic [7:0] n, input int eod);
    logic [7:0] b;
    logic [7:0] exp_rec [7];
    int got;
    bit ab;
    eod_at = eod; dcount = 0; seed = c ^ r;
    host_write({3'b010, 5'h06}, "R2");
    chk(msr == 8'h10, "R2", msr, 8'h10);
    host_write({5'b0, 1'(h), 2'(d)}, "R2");
    host_write(c, "R2"); host_write(hh, "R2"); host_write(r, "R2"); host_write(n, "R2");
    host_write(8'h09, "R2"); host_write(8'h2a, "R2");
    wait_rqm(1'b0, "R2");
    chk(msr == 8'h90, "R2", msr, 8'h90);
    host_write(8'hff, "R2");
    got = 0;
    for (int k = 0; k < SEC; k++) begin
      if (k == eod) break;
      wait_rqm(1'b1, "R5");
      chk(msr == (8'hF0 | (8'h01 << d)), "R5", msr, 8'hF0 | (8'h01 << d));
      host_read(b, "R5");
      chk(b == seed + 8'(k * 7), "R5", b, seed + 8'(k * 7));
      got++;
    end
    ab = (eod < SEC);
    if (ab) chk(got == eod, "R7", got, eod);
    wait_rqm(1'b1, "R6");
    host_wdata = 8'h55; host_wr_stb = 1'b1;
    @(negedge clk);
    host_wr_stb = 1'b0;
    chk(msr == 8'hD0, "R8", msr, 8'hD0);
    exp_rec[0] = {ab ? 2'b01 : 2'b00, 3'b000, 1'(h), 2'(d)};
    exp_rec[1] = ab ? 8'h04 : 8'h00;
    exp_rec[2] = 8'h00;
    exp_rec[3] = c; exp_rec[4] = hh; exp_rec[5] = r; exp_rec[6] = n;
    for (int i = 0; i < 7; i++) begin
      wait_rqm(1'b1, "R9");
      chk(msr == 8'hD0, "R9", msr, 8'hD0);
      host_read(b, ab ? "R7" : "R6");
      chk(b == exp_rec[i], ab ? "R7" : "R6", b, exp_rec[i]);
    end
    @(negedge clk);
    chk(msr == 8'h80, "R9", msr, 8'h80);
  endtask

  initial begin
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(msr == 8'h80, "R1", msr, 8'h80);
    chk(host_rdata == 8'h00, "R1", host_rdata, 0);

    // R8: a read strobe in the command phase changes nothing
    host_rd_stb = 1'b1; @(negedge clk); host_rd_stb = 1'b0;
    chk(msr == 8'h80, "R8", msr, 8'h80);

    // R3: three-byte timing command, no execution or result
    host_write(8'h03, "R3");
    host_write(8'hdf, "R3");
    host_write(8'h02, "R3");
    chk(msr == 8'h00, "R3", msr, 8'h00);
    @(negedge clk);
    chk(msr == 8'h80, "R3", msr, 8'h80);

    // R4: every unknown opcode
    for (int code = 0; code < 32; code++) begin
      if (code == 3 || code == 6) continue;
      host_write({3'(code), 5'(code)}, "R4");
      wait_rqm(1'b1, "R4");
      chk(msr == 8'hD0, "R4", msr, 8'hD0);
      host_read(b, "R4");
      chk(b == 8'h80, "R4", b, 8'h80);
      @(negedge clk);
      chk(msr == 8'h80, "R4", msr, 8'h80);
    end

    // R5 R6: every drive and head, full transfers
    for (int d = 0; d < 4; d++)
      for (int h = 0; h < 2; h++)
        do_read(d, h, 8'(d * 9 + 1), 8'(h), 8'(d + h * 4 + 1), 8'(2 + d), 99);

    // R7: early end at every byte position
    for (int e = 0; e < SEC; e++)
      do_read(2, 1, 8'(40 + e), 8'h01, 8'(e + 3), 8'h02, e);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule